// File: doc/BRIEF.md
# Floating-Point Operand and Result Modifier Unit

This block sits beside a vector arithmetic pipe and applies the modifier bits that the three-operand instruction format carries. On the operand side it takes three single-precision sources. For each source a magnitude bit and a sign-flip bit are applied before the operation runs. On the result side it takes one single-precision value, a two-bit power-of-two scale code and a saturate bit, and returns the adjusted value. All of this is done by editing the sign and exponent fields, so no adder or multiplier is involved.

A bypass input turns every modifier off. It is used for the conditional-select and integer operations, whose operands and results must pass bit for bit. Both paths are registered once, so each output follows its inputs by one clock. The arithmetic operation itself lies outside the block.

Top module: `fpmod_unit`

## Requirements
- R1: When bit i of `abs_mask` is set (bit 0 = source 0, bit 1 = source 1, bit 2 = source 2) and `bypass` is low, bit 31 of source i is cleared.
- R2: When bit i of `neg_mask` is set and `bypass` is low, bit 31 of source i is inverted after the magnitude step. With both mask bits set, the sign is therefore always 1 (-|x|).
- R3: The source modifiers never change bits 30:0 of any source.
- R4: The scale code `oscale` means 0 = unchanged, 1 = ×2, 2 = ×4 and 3 = ×0.5. Scaling adds 1 or 2 to the exponent field (bits 30:23), or subtracts 1 from it, and keeps the sign and the mantissa.
- R5: If scaling up gives an exponent of 255 or more, the result becomes an infinity of the same sign (exponent 255, mantissa 0).
- R6: With a nonzero code, an input whose exponent is 0, or a ×0.5 applied to exponent 1, gives a zero of the same sign.
- R7: An input with exponent 255 (infinity or NaN) passes through scaling unchanged.
- R8: With `clamp_en` set, a NaN or any value with sign 1 (including -0.0) gives 0x00000000. A value of 1.0 or more (0x3F800000) gives 0x3F800000. Any other value passes unchanged.
- R9: Scaling is applied before clamping.
- R10: With `bypass` high, `src_out` equals `src_in` and `res_out` equals `res_in`, whatever the masks, code and clamp bit are.
- R11: Every output is registered with a latency of one clock, and a synchronous reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bypass | input | 1 | Disables all modifiers |
| src_in | input | 96 | Sources, source i at bits 32i+31:32i |
| abs_mask | input | 3 | Per-source magnitude enables |
| neg_mask | input | 3 | Per-source sign-flip enables |
| res_in | input | 32 | Operation result |
| clamp_en | input | 1 | Saturate result to [0,1] |
| oscale | input | 2 | Result scale code |
| src_out | output | 96 | Modified sources |
| res_out | output | 32 | Scaled and clamped result |

## Verification
The result path is tried with four groups of values:
- Ordinary normals under every scale code, which tells the three exponent offsets apart.
- Values at the exponent edges (254, 1, 0 and 255), which separate saturation to infinity, flushing to zero and passing through unchanged.
- Clamp inputs below zero, inside the range, above one, -0.0 and NaN.
- Two scale-plus-clamp cases, whose answer shows whether scaling comes before clamping.

The source path is driven with negative, positive and NaN operands under mixed masks, so that a swapped mask bit or a wrong abs/negate order shows up. A final run with bypass high and every modifier set confirms that the bypass leaves all values untouched.

// File: rtl/fpmod_pkg.sv
package fpmod_pkg;
    localparam int FW      = 32;
    localparam int EW      = 8;
    localparam int MW      = FW - EW - 1;
    localparam int NSRC    = 3;
    localparam int EXP_TOP = (1 << EW) - 1;

    typedef enum logic [1:0] {
        OSC_NONE = 2'd0,
        OSC_X2   = 2'd1,
        OSC_X4   = 2'd2,
        OSC_HALF = 2'd3
    } oscale_e;

    typedef struct packed {
        logic          sign;
        logic [EW-1:0] exp;
        logic [MW-1:0] man;
    } fp_t;

    localparam fp_t FP_ONE = '{sign: 1'b0, exp: EW'((1 << (EW - 1)) - 1), man: '0};

    function automatic logic fp_is_nan(fp_t v);
        return (v.exp == '1) && (v.man != '0);
    endfunction

    function automatic fp_t fp_signed_zero(logic s);
        fp_t z;
        z = '0;
        z.sign = s;
        return z;
    endfunction
endpackage

// File: rtl/fpmod_src.sv
module fpmod_src
    import fpmod_pkg::*;
(
    input  fp_t  a,
    input  logic abs_en,
    input  logic neg_en,
    input  logic bypass,
    output fp_t  y
);
    logic mag_sign;

    always_comb begin
        mag_sign = a.sign & ~abs_en;
        y        = a;
        if (!bypass) begin
            y.sign = mag_sign ^ neg_en;
        end
    end
endmodule

// File: rtl/fpmod_scale.sv
module fpmod_scale
    import fpmod_pkg::*;
(
    input  fp_t     a,
    input  oscale_e code,
    output fp_t     y
);
    logic [EW:0] sum;

    always_comb begin
        y   = a;
        sum = '0;
        if (code != OSC_NONE && a.exp != '1) begin
            if (a.exp == '0) begin
                y = fp_signed_zero(a.sign);
            end else if (code == OSC_HALF) begin
                if (a.exp == EW'(1)) begin
                    y = fp_signed_zero(a.sign);
                end else begin
                    y.exp = a.exp - EW'(1);
                end
            end else begin
                sum = {1'b0, a.exp} + ((code == OSC_X4) ? (EW+1)'(2) : (EW+1)'(1));
                if (sum >= (EW+1)'(EXP_TOP)) begin
                    y.exp = '1;
                    y.man = '0;
                end else begin
                    y.exp = sum[EW-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/fpmod_clamp.sv
module fpmod_clamp
    import fpmod_pkg::*;
(
    input  fp_t  a,
    input  logic en,
    output fp_t  y
);
    always_comb begin
        y = a;
        if (en) begin
            if (fp_is_nan(a) || a.sign) begin
                y = '0;
            end else if (a >= FP_ONE) begin
                y = FP_ONE;
            end
        end
    end
endmodule

// File: rtl/fpmod_unit.sv
module fpmod_unit
    import fpmod_pkg::*;
#(
    parameter int N_SRC = NSRC
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bypass,
    input  logic [N_SRC*FW-1:0] src_in,
    input  logic [N_SRC-1:0]   abs_mask,
    input  logic [N_SRC-1:0]   neg_mask,
    input  logic [FW-1:0]      res_in,
    input  logic               clamp_en,
    input  logic [1:0]         oscale,
    output logic [N_SRC*FW-1:0] src_out,
    output logic [FW-1:0]      res_out
);
    fp_t src_mod [N_SRC];
    fp_t src_q   [N_SRC];
    fp_t res_scaled;
    fp_t res_clamped;
    fp_t res_d;
    fp_t res_q;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        fpmod_src u_src (
            .a      (fp_t'(src_in[i*FW +: FW])),
            .abs_en (abs_mask[i]),
            .neg_en (neg_mask[i]),
            .bypass (bypass),
            .y      (src_mod[i])
        );

        always_ff @(posedge clk) begin
            if (rst) src_q[i] <= '0;
            else     src_q[i] <= src_mod[i];
        end

        assign src_out[i*FW +: FW] = src_q[i];
    end

    fpmod_scale u_scale (
        .a    (fp_t'(res_in)),
        .code (oscale_e'(oscale)),
        .y    (res_scaled)
    );

    fpmod_clamp u_clamp (
        .a  (res_scaled),
        .en (clamp_en),
        .y  (res_clamped)
    );

    assign res_d = bypass ? fp_t'(res_in) : res_clamped;

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    assign res_out = res_q;
endmodule

// File: rtl/fpmod_chk.sv
module fpmod_chk
    import fpmod_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               bypass,
    input logic [NSRC*FW-1:0] src_in,
    input logic [NSRC-1:0]    abs_mask,
    input logic [NSRC-1:0]    neg_mask,
    input logic [FW-1:0]      res_in,
    input logic               clamp_en,
    input logic [1:0]         oscale,
    input logic [NSRC*FW-1:0] src_out,
    input logic [FW-1:0]      res_out
);
    logic seen_q;

    always_ff @(posedge clk) begin
        if (rst) seen_q <= 1'b0;
        else     seen_q <= 1'b1;
    end

    // R1
    src_abs_chk: assert property (@(posedge clk) disable iff (rst)
        seen_q && !$past(bypass) && $past(abs_mask[0]) && !$past(neg_mask[0]) |-> !src_out[31]);

    // R2
    src_negabs_chk: assert property (@(posedge clk) disable iff (rst)
        seen_q && !$past(bypass) && $past(abs_mask[1]) && $past(neg_mask[1]) |-> src_out[63]);

    // R3
    src_body_chk: assert property (@(posedge clk) disable iff (rst)
        seen_q |-> (src_out[30:0] == $past(src_in[30:0])) && (src_out[62:32] == $past(src_in[62:32]))
                   && (src_out[94:64] == $past(src_in[94:64])));

    // R7
    special_keep_chk: assert property (@(posedge clk) disable iff (rst)
        seen_q && !$past(clamp_en) && ($past(res_in[30:23]) == 8'hFF) |-> res_out == $past(res_in));

    // R8
    clamp_range_chk: assert property (@(posedge clk) disable iff (rst)
        seen_q && $past(clamp_en) && !$past(bypass) |-> !res_out[31] && (res_out <= 32'h3F80_0000));

    // R10
    bypass_chk: assert property (@(posedge clk) disable iff (rst)
        seen_q && $past(bypass) |-> (res_out == $past(res_in)) && (src_out == $past(src_in)));
endmodule

bind fpmod_unit fpmod_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .bypass   (bypass),
    .src_in   (src_in),
    .abs_mask (abs_mask),
    .neg_mask (neg_mask),
    .res_in   (res_in),
    .clamp_en (clamp_en),
    .oscale   (oscale),
    .src_out  (src_out),
    .res_out  (res_out)
);

// File: tb/sim_fpmod_unit.sv
`timescale 1ns/1ps
module sim_fpmod_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bypass = 1'b0;
    logic [95:0] src_in = '0;
    logic [2:0]  abs_mask = '0;
    logic [2:0]  neg_mask = '0;
    logic [31:0] res_in = '0;
    logic        clamp_en = 1'b0;
    logic [1:0]  oscale = '0;
    logic [95:0] src_out;
    logic [31:0] res_out;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    fpmod_unit u0 (
        .clk(clk), .rst(rst), .bypass(bypass), .src_in(src_in),
        .abs_mask(abs_mask), .neg_mask(neg_mask), .res_in(res_in),
        .clamp_en(clamp_en), .oscale(oscale), .src_out(src_out), .res_out(res_out)
    );

    // entry: {req[3:0], res_in[31:0], clamp, code[1:0], expected[31:0]}
    localparam int NV = 19;
    localparam logic [70:0] RV [NV] = '{
        {4'd4,  32'h3F80_0000, 1'b0, 2'd1, 32'h4000_0000}, // R4 1.0 x2
        {4'd4,  32'h3F80_0000, 1'b0, 2'd2, 32'h4080_0000}, // R4 1.0 x4
        {4'd4,  32'h3F80_0000, 1'b0, 2'd3, 32'h3F00_0000}, // R4 1.0 x0.5
        {4'd4,  32'h3FC0_0000, 1'b0, 2'd0, 32'h3FC0_0000}, // R4 no scale
        {4'd4,  32'hC040_0000, 1'b0, 2'd1, 32'hC0C0_0000}, // R4 -3 x2
        {4'd5,  32'h7F7F_FFFF, 1'b0, 2'd1, 32'h7F80_0000}, // R5 max x2
        {4'd5,  32'hFF00_0000, 1'b0, 2'd2, 32'hFF80_0000}, // R5 neg overflow
        {4'd6,  32'h8080_0000, 1'b0, 2'd3, 32'h8000_0000}, // R6 min normal /2
        {4'd6,  32'h0040_0000, 1'b0, 2'd1, 32'h0000_0000}, // R6 denormal x2
        {4'd6,  32'h8000_0000, 1'b0, 2'd2, 32'h8000_0000}, // R6 -0 x4
        {4'd7,  32'h7FC0_0001, 1'b0, 2'd1, 32'h7FC0_0001}, // R7 NaN
        {4'd7,  32'hFF80_0000, 1'b0, 2'd3, 32'hFF80_0000}, // R7 -inf
        {4'd8,  32'h3F00_0000, 1'b1, 2'd0, 32'h3F00_0000}, // R8 in range
        {4'd8,  32'hBF00_0000, 1'b1, 2'd0, 32'h0000_0000}, // R8 negative
        {4'd8,  32'h4000_0000, 1'b1, 2'd0, 32'h3F80_0000}, // R8 above one
        {4'd8,  32'h7FC0_0000, 1'b1, 2'd0, 32'h0000_0000}, // R8 NaN
        {4'd8,  32'h8000_0000, 1'b1, 2'd0, 32'h0000_0000}, // R8 -0
        {4'd9,  32'h3F40_0000, 1'b1, 2'd1, 32'h3F80_0000}, // R9 0.75 x2 then clamp
        {4'd9,  32'h4000_0000, 1'b1, 2'd3, 32'h3F80_0000}  // R9 2.0 /2 then clamp
    };

    task automatic check(string req, logic [95:0] got, logic [95:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        step();
        check("R11 reset res", {64'h0, res_out}, 96'h0);
        check("R11 reset src", src_out, 96'h0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            res_in   = RV[i][66:35];
            clamp_en = RV[i][34];
            oscale   = RV[i][33:32];
            step();
            check($sformatf("R%0d vec %0d", RV[i][70:67], i), {64'h0, res_out}, {64'h0, RV[i][31:0]});
        end

        // R1 R2 mixed masks: src0 -2.0 abs, src1 1.0 neg, src2 NaN untouched
        @(negedge clk);
        clamp_en = 1'b0; oscale = 2'd0;
        src_in   = {32'h7FC0_0001, 32'h3F80_0000, 32'hC000_0000};
        abs_mask = 3'b001; neg_mask = 3'b010;
        step();
        check("R1 abs src0", {64'h0, src_out[31:0]}, {64'h0, 32'h4000_0000});
        check("R2 neg src1", {64'h0, src_out[63:32]}, {64'h0, 32'hBF80_0000});
        check("R3 src2 kept", {64'h0, src_out[95:64]}, {64'h0, 32'h7FC0_0001});

        // R2 abs then neg on src2 and src0 (negative input)
        @(negedge clk);
        abs_mask = 3'b101; neg_mask = 3'b101;
        step();
        check("R2 negabs src2", {64'h0, src_out[95:64]}, {64'h0, 32'hFFC0_0001});
        check("R2 negabs src0", {64'h0, src_out[31:0]}, {64'h0, 32'hC000_0000});
        check("R1 src1 unmasked", {64'h0, src_out[63:32]}, {64'h0, 32'h3F80_0000});

        // R10 bypass with every modifier active
        @(negedge clk);
        bypass = 1'b1; abs_mask = 3'b111; neg_mask = 3'b111;
        clamp_en = 1'b1; oscale = 2'd1; res_in = 32'hC123_4567;
        src_in = {32'h8000_0001, 32'hFF80_0000, 32'h1234_5678};
        step();
        check("R10 bypass res", {64'h0, res_out}, {64'h0, 32'hC123_4567});
        check("R10 bypass src", src_out, {32'h8000_0001, 32'hFF80_0000, 32'h1234_5678});

        // R11 latency: output holds until the next edge
        @(negedge clk);
        bypass = 1'b0; clamp_en = 1'b0; oscale = 2'd2; res_in = 32'h3F80_0000;
        #0.5;
        check("R11 latency hold", {64'h0, res_out}, {64'h0, 32'hC123_4567});
        step();
        check("R11 latency update", {64'h0, res_out}, {64'h0, 32'h4080_0000});

        // R11 synchronous reset clears outputs
        @(negedge clk);
        rst = 1'b1;
        step();
        check("R11 reset again", {64'h0, res_out}, 96'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 5000) begin
            checks++;
            fails++;
            $display("FAIL watchdog got=%0d exp<=5000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule